// File: doc/BRIEF.md
# LED Column-Driver Register Init Sequencer

This block produces the power-up configuration stream that certain LED column-driver chips expect before they will show any image. A single start pulse launches the sequence. Each register write shifts a fixed 16-bit pattern across the whole chained column width, one clock per column, on every colour data line at once. The pattern repeats every sixteen columns. The driver chips tell register writes apart by counting the clocks at the tail of a write during which the latch line is high. The sequencer therefore raises the latch near the end of each write, and the tail length depends on the register being written.

Two variants are selected at start time. The two-register variant writes a full-brightness pattern and then a panel-enable pattern, and it holds row address line A high for the whole sequence. The three-register variant writes the same two patterns with A left low, and then writes a third pattern. A one-cycle done pulse marks the end of the sequence.

The sequencer is a Moore state machine with six states:

| State | Role |
|---|---|
| `ST_IDLE` | Quiet outputs; waits for start. |
| `ST_PREP` | Column count and variant are captured; clock and latch are low. |
| `ST_LOW` | Clock low; data and latch are presented for the current column. |
| `ST_HIGH` | Clock high; data and latch are held. |
| `ST_RELEASE` | Clock low, latch low and data low after a register's last column. |
| `ST_DONE` | Done pulse. |

Transitions:

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_PREP` | Start is high. |
| `ST_PREP` | `ST_LOW` | Captured column count is non-zero. |
| `ST_PREP` | `ST_RELEASE` | Captured column count is zero. |
| `ST_LOW` | `ST_HIGH` | Always. |
| `ST_HIGH` | `ST_LOW` | Current column is not the last one. |
| `ST_HIGH` | `ST_RELEASE` | Current column is the last one. |
| `ST_RELEASE` | `ST_LOW` | Another register remains and the column count is non-zero. |
| `ST_RELEASE` | `ST_RELEASE` | Another register remains and the column count is zero. |
| `ST_RELEASE` | `ST_DONE` | The final register is finished. |
| `ST_DONE` | `ST_IDLE` | Always. |

Top module: `ledcfg_init_seq`

## Requirements
- R1: After reset, and in idle, `sclk`, `latch`, `rgb_data`, `addr_a` and `done` are all low.
- R2: A start pulse sampled in idle begins the sequence. Its first cycle drives clock and latch low, and `addr_a` already shows its variant level.
- R3: Each register write gives exactly N clock pulses, where N is the captured column count. Each pulse is one cycle high followed by at least one cycle low. Data and latch change only while `sclk` is low.
- R4: At column i, where i counts from 0, every bit of `rgb_data` equals character (i mod 16) of the register's pattern. The leftmost character is used at i mod 16 = 0.
- R5: During column i, `latch` is high exactly when i > N − T. T is 12 for register 0, 13 for register 1 and 11 for register 2.
- R6: After each register's last clock, one cycle follows with clock, latch and data low before the next register or the end.
- R7: With `three_reg` = 0, two registers are written: 0111111111111111, then 0000000001000000. `addr_a` is high from the first sequence cycle through the final release cycle.
- R8: With `three_reg` = 1, `addr_a` stays low. After the two patterns of R7, a third register is written with pattern 0101111100000000.
- R9: `done` is high for exactly one cycle, in the cycle after the final release cycle. The block then returns to idle.
- R10: Start pulses, and changes of `col_count` or `three_reg`, have no effect while a sequence runs. The running sequence keeps its captured values, and no second sequence follows.
- R11: A column count of 0 gives no clock pulses. The sequence runs the prep cycle, one release cycle per register and then done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled only in idle |
| col_count | input | COL_W | Number of chained columns N, captured at launch |
| three_reg | input | 1 | 0: two-register variant; 1: three-register variant |
| rgb_data | output | LANES | Colour data lines, all carrying the same bit |
| sclk | output | 1 | Shift clock to the column drivers |
| latch | output | 1 | Latch line; its tail length selects the register |
| addr_a | output | 1 | Row address line A |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The hardest situations to reach are the latch-window edges, where N is close to the tail lengths 11, 12 and 13. In these cases the window covers all columns, or its lower bound lands exactly on column 0. The zero-column case is also hard to reach. The bench sweeps every column count from 0 to 40, plus the maximum, in both variants, and compares every output on every cycle against a trace computed arithmetically. On some runs it also pulses start again and rewrites the inputs part-way through, to show that the captured values are kept.

// File: rtl/ledcfg_pkg.sv
package ledcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_LOW,
        ST_HIGH,
        ST_RELEASE,
        ST_DONE
    } seq_state_t;

    localparam int PAT_LEN = 16;

    // Character 0 of each pattern sits at index 0 (leftmost).
    localparam logic [0:PAT_LEN-1] PAT_FULL_BRIGHT = 16'b0111111111111111;
    localparam logic [0:PAT_LEN-1] PAT_PANEL_ON    = 16'b0000000001000000;
    localparam logic [0:PAT_LEN-1] PAT_EXTRA       = 16'b0101111100000000;

    // Latch-tail bound for each register: latch is high while col > N - tail.
    localparam int TAIL_REG0 = 12;
    localparam int TAIL_REG1 = 13;
    localparam int TAIL_REG2 = 11;

    function automatic logic [0:PAT_LEN-1] pattern_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return PAT_FULL_BRIGHT;
            2'd1:    return PAT_PANEL_ON;
            default: return PAT_EXTRA;
        endcase
    endfunction

    function automatic int tail_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return TAIL_REG0;
            2'd1:    return TAIL_REG1;
            default: return TAIL_REG2;
        endcase
    endfunction

endpackage

// File: rtl/ledcfg_colctr.sv
module ledcfg_colctr #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [COL_W-1:0] limit,
    output logic [COL_W-1:0] idx,
    output logic             is_last
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (inc) begin
            idx <= idx + ONE;
        end
    end

    always_comb begin
        is_last = (idx == limit - ONE);
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0) |-> (idx < limit)); // R3

endmodule

// File: rtl/ledcfg_pattern.sv
module ledcfg_pattern
    import ledcfg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [1:0]       reg_sel,
    input  logic [COL_W-1:0] col_idx,
    input  logic [COL_W-1:0] col_total,
    output logic             pat_bit,
    output logic             latch_win
);

    localparam int SUM_W = COL_W + 1;

    logic [0:PAT_LEN-1] pat;
    logic [3:0]         phase;
    logic [SUM_W-1:0]   reach;

    always_comb begin
        pat     = pattern_of(reg_sel);
        phase   = col_idx[3:0];
        pat_bit = pat[phase];
        // col > N - tail  <=>  col + tail > N, kept unsigned and wide.
        reach     = {1'b0, col_idx} + SUM_W'(tail_of(reg_sel));
        latch_win = (reach > {1'b0, col_total});
    end

endmodule

// File: rtl/ledcfg_init_seq.sv
module ledcfg_init_seq
    import ledcfg_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int LANES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] col_count,
    input  logic             three_reg,
    output logic [LANES-1:0] rgb_data,
    output logic             sclk,
    output logic             latch,
    output logic             addr_a,
    output logic             done
);

    seq_state_t       state, nxt;
    logic [COL_W-1:0] cap_n;
    logic             cap_three;
    logic [1:0]       reg_idx;
    logic             reg_last;
    logic             no_cols;
    logic [COL_W-1:0] col_idx;
    logic             col_last;
    logic             ctr_clr, ctr_inc;
    logic             pat_bit, latch_win;
    logic             shifting;

    ledcfg_colctr #(.COL_W(COL_W)) u_colctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctr_clr),
        .inc     (ctr_inc),
        .limit   (cap_n),
        .idx     (col_idx),
        .is_last (col_last)
    );

    ledcfg_pattern #(.COL_W(COL_W)) u_pattern (
        .reg_sel   (reg_idx),
        .col_idx   (col_idx),
        .col_total (cap_n),
        .pat_bit   (pat_bit),
        .latch_win (latch_win)
    );

    always_comb begin
        reg_last = cap_three ? (reg_idx == 2'd2) : (reg_idx == 2'd1);
        no_cols  = (cap_n == '0);
        shifting = (state == ST_LOW) || (state == ST_HIGH);
        ctr_clr  = !shifting;
        ctr_inc  = (state == ST_HIGH) && !col_last;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    nxt = start ? ST_PREP : ST_IDLE;
            ST_PREP:    nxt = no_cols ? ST_RELEASE : ST_LOW;
            ST_LOW:     nxt = ST_HIGH;
            ST_HIGH:    nxt = col_last ? ST_RELEASE : ST_LOW;
            ST_RELEASE: begin
                if (reg_last)     nxt = ST_DONE;
                else if (no_cols) nxt = ST_RELEASE;
                else              nxt = ST_LOW;
            end
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Launch context: captured once, register index advanced per release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_n     <= '0;
            cap_three <= 1'b0;
            reg_idx   <= 2'd0;
        end else begin
            if (state == ST_IDLE) begin
                reg_idx <= 2'd0;
                if (start) begin
                    cap_n     <= col_count;
                    cap_three <= three_reg;
                end
            end else if (state == ST_RELEASE && !reg_last) begin
                reg_idx <= reg_idx + 2'd1;
            end
        end
    end

    // Moore outputs
    always_comb begin
        sclk     = (state == ST_HIGH);
        latch    = shifting && latch_win;
        rgb_data = (shifting && pat_bit) ? {LANES{1'b1}} : {LANES{1'b0}};
        addr_a   = !cap_three && ((state == ST_PREP) || shifting ||
                                  (state == ST_RELEASE));
        done     = (state == ST_DONE);
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sclk && !latch && !done)); // R1

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> ($stable(rgb_data) && $stable(latch))); // R3

    AST_LATCH_RISE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch) |-> !sclk); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_RELEASE && !$past(latch))); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> (state != ST_PREP)); // R10

endmodule

// File: tb/sim_ledcfg_init_seq.sv
module sim_ledcfg_init_seq;

    localparam int COL_W = 8;
    localparam int LANES = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic [COL_W-1:0] col_count;
    logic             three_reg;
    logic [LANES-1:0] rgb_data;
    logic             sclk, latch, addr_a, done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc;
    bit cur_disturb;
    int cur_n;
    bit cur_v;

    always #5 clk = ~clk;

    ledcfg_init_seq #(.COL_W(COL_W), .LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .col_count(col_count),
        .three_reg(three_reg), .rgb_data(rgb_data), .sclk(sclk),
        .latch(latch), .addr_a(addr_a), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s n=%0d v=%0d cyc=%0d actual=%0d expected=%0d",
                     req, what, cur_n, cur_v, cyc, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int r, input int i);
        logic [0:15] p;
        case (r)
            0:       p = 16'b0111111111111111;
            1:       p = 16'b0000000001000000;
            default: p = 16'b0101111100000000;
        endcase
        return p[i % 16];
    endfunction

    function automatic bit exp_latch(input int r, input int i, input int n);
        int t;
        t = (r == 0) ? 12 : (r == 1) ? 13 : 11;
        return i > n - t;
    endfunction

    task automatic expect_all(input bit e_clk, input bit e_lat, input bit e_dat,
                              input bit e_adr, input bit e_done,
                              input string rq_clk, input string rq_lat,
                              input string rq_dat, input string rq_adr,
                              input string rq_done);
        logic [LANES-1:0] dexp;
        dexp = e_dat ? {LANES{1'b1}} : {LANES{1'b0}};
        chk(sclk == e_clk, rq_clk, "sclk", int'(sclk), int'(e_clk));
        chk(latch == e_lat, rq_lat, "latch", int'(latch), int'(e_lat));
        chk(rgb_data == dexp, rq_dat, "rgb_data", int'(rgb_data), int'(dexp));
        chk(addr_a == e_adr, rq_adr, "addr_a", int'(addr_a), int'(e_adr));
        chk(done == e_done, rq_done, "done", int'(done), int'(e_done));
    endtask

    task automatic advance();
        @(negedge clk);
        cyc++;
        if (cur_disturb && cyc == 2) begin
            start     = 1'b1;
            col_count = ~col_count;
            three_reg = ~three_reg;
        end else if (cur_disturb && cyc == 3) begin
            start = 1'b0;
        end
    endtask

    task automatic run_seq(input int n, input bit v, input bit disturb);
        int    nreg;
        bit    adr;
        string rq_adr, rq_dat, rq_rel, rq_idle;
        cur_n       = n;
        cur_v       = v;
        cur_disturb = disturb;
        cyc         = 0;
        nreg    = v ? 3 : 2;
        adr     = !v;
        rq_adr  = v ? "R8" : "R7";
        rq_rel  = (n == 0) ? "R11" : "R6";
        rq_idle = disturb ? "R10" : "R9";
        @(negedge clk);
        col_count = COL_W'(n);
        three_reg = v;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // prep cycle (R2)
        expect_all(0, 0, 0, adr, 0, "R2", "R2", "R2", rq_adr, "R9");
        for (int r = 0; r < nreg; r++) begin
            rq_dat = (r == 2) ? "R8" : (v ? "R4" : "R7");
            for (int i = 0; i < n; i++) begin
                advance();
                expect_all(0, exp_latch(r, i, n), exp_bit(r, i), adr, 0,
                           "R3", "R5", rq_dat, rq_adr, "R9");
                advance();
                expect_all(1, exp_latch(r, i, n), exp_bit(r, i), adr, 0,
                           "R3", "R5", "R4", rq_adr, "R9");
            end
            advance();
            expect_all(0, 0, 0, adr, 0, rq_rel, rq_rel, rq_rel, rq_adr, "R9");
        end
        advance();
        expect_all(0, 0, 0, 0, 1, "R9", "R9", "R9", "R9", "R9");
        for (int k = 0; k < 3; k++) begin
            advance();
            expect_all(0, 0, 0, 0, 0, rq_idle, rq_idle, rq_idle, rq_idle, rq_idle);
        end
        cur_disturb = 0;
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        col_count = '0;
        three_reg = 1'b0;
        cur_n = 0;
        cur_v = 0;
        cyc = 0;
        cur_disturb = 0;
        repeat (3) @(negedge clk);
        expect_all(0, 0, 0, 0, 0, "R1", "R1", "R1", "R1", "R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_all(0, 0, 0, 0, 0, "R1", "R1", "R1", "R1", "R1");
        for (int v = 0; v < 2; v++) begin
            for (int n = 0; n <= 40; n++) begin
                run_seq(n, v[0], (n % 7) == 3);
            end
            run_seq((1 << COL_W) - 1, v[0], 1'b1);
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule